// File: doc/BRIEF.md
# Pixel Clock Ratio Search Engine

This block chooses the multiplier `v` and divider `r` of a frequency synthesiser so that the synthesised rate lands as close as possible to a requested pixel rate. The rate for a pair is the reference frequency times `v`, divided by 1000, then divided by `r`. Each division truncates to an integer. Instead of solving for the ratio directly, the engine tries every pair in a fixed descending order. It keeps the pair with the smallest absolute error and reports it as one packed control word.

A request arrives on a valid/ready channel. `req_ready` is high only while the engine is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The caller may hold `req_valid` high as long as it likes; the engine applies back-pressure simply by keeping `req_ready` low while a search runs.

The result leaves as a one-cycle `res_valid` pulse with no back-pressure. `res_code` keeps its value until the next request is accepted, so a slow consumer can still read it after the pulse. All divisions go through one shared iterative divider that retires several quotient bits per clock. With the default settings, one search takes roughly sixteen thousand cycles.

Top module: `pixclk_ratio_search`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, `res_valid` is 0 and `res_code` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle after the result pulse. `req_valid`, `req_fref` and `req_rate` have no effect on a running search. A request held high across the result pulse is accepted on the edge that follows the pulse.
- R3: For each candidate, the rate is `((v * req_fref) / 1000) / r`, with both divisions truncating. `v` and `r` each take every value from 1 to 63.
- R4: The candidate order is `v` from 63 down to 1 in the outer loop, and `r` from 63 down to 1 inside it. A candidate becomes the best pair when its error is less than or equal to the best error so far. On a tie, the later and smaller pair therefore wins.
- R5: The error is the absolute difference between the candidate rate and `req_rate`, both taken as unsigned values. The best error starts at 2^31-1, so a candidate whose error exceeds 2^31-1 is never chosen.
- R6: `res_code[13:8]` holds `v-1` and `res_code[5:0]` holds `r-1`. All other bits of `res_code` are 0. If no candidate was chosen, the pair is clamped to `v=1`, `r=1`, so `res_code` is 0x0000.
- R7: `res_valid` is high for exactly one cycle per accepted request. `res_code` changes only in that cycle and then holds until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_fref | input | 32 | Reference frequency |
| req_rate | input | 32 | Requested pixel rate, same units as the candidate formula |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | 16 | Packed result: v-1 in [13:8], r-1 in [5:0] |

## Verification
The end of one search can coincide with the arrival of the next request. In the same cycle that `res_valid` pulses, a new request may already be waiting with `req_valid` held high. The bench starts a search and changes the request inputs while it runs, keeping `req_valid` high through the pulse. It then judges three things: the first result must reflect only the original inputs; `req_ready` must return exactly on the cycle after the pulse; and the waiting request must then run to its own correct result.

// File: rtl/pixclk_ratio_pkg.sv
package pixclk_ratio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK_SCALE,
    ST_WAIT_SCALE,
    ST_KICK_RATIO,
    ST_WAIT_RATIO,
    ST_PACK,
    ST_REPORT
  } search_state_e;

endpackage

// File: rtl/pixclk_ratio_div.sv
// Iterative restoring divider, STEPS quotient bits per clock.
module pixclk_ratio_div #(
  parameter int DVD_W = 38,
  parameter int DVS_W = 10,
  parameter int STEPS = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);

  localparam int ITER  = (DVD_W + STEPS - 1) / STEPS;
  localparam int PAD_W = ITER * STEPS;
  localparam int CNT_W = $clog2(ITER + 1);

  logic [PAD_W-1:0] work_q, work_c;
  logic [DVS_W-1:0] rem_q, rem_c, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [DVS_W:0]   trial;

  always_comb begin
    rem_c  = rem_q;
    work_c = work_q;
    trial  = '0;
    for (int i = 0; i < STEPS; i++) begin
      trial  = {rem_c, work_c[PAD_W-1]};
      work_c = {work_c[PAD_W-2:0], 1'b0};
      if (trial >= {1'b0, dvs_q}) begin
        trial     = trial - {1'b0, dvs_q};
        work_c[0] = 1'b1;
      end
      rem_c = trial[DVS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && cnt_q == '0) begin
        work_q <= PAD_W'(dividend);
        rem_q  <= '0;
        dvs_q  <= divisor;
        cnt_q  <= CNT_W'(ITER);
      end else if (cnt_q != '0) begin
        work_q <= work_c;
        rem_q  <= rem_c;
        cnt_q  <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done     = done_q;
  assign quotient = work_q[DVD_W-1:0];

endmodule

// File: rtl/pixclk_ratio_best.sv
// Keeps the best (v, r) pair; replaces on error less than or equal.
module pixclk_ratio_best #(
  parameter int FREQ_W = 38,
  parameter int RATE_W = 32,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cand_valid,
  input  logic [FREQ_W-1:0] cand_freq,
  input  logic [SEL_W-1:0]  cand_v,
  input  logic [SEL_W-1:0]  cand_r,
  input  logic [RATE_W-1:0] target,
  output logic [SEL_W-1:0]  best_v,
  output logic [SEL_W-1:0]  best_r
);

  localparam logic [RATE_W-1:0] INIT_ERR = {1'b0, {(RATE_W-1){1'b1}}};

  logic [RATE_W-1:0] best_err_q;
  logic [SEL_W-1:0]  v_q, r_q;
  logic [FREQ_W-1:0] tgt_ext, diff;
  logic              take;

  assign tgt_ext = FREQ_W'(target);
  assign diff    = (cand_freq >= tgt_ext) ? (cand_freq - tgt_ext) : (tgt_ext - cand_freq);
  assign take    = cand_valid && (diff <= FREQ_W'(best_err_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err_q <= INIT_ERR;
      v_q        <= '0;
      r_q        <= '0;
    end else if (clear) begin
      best_err_q <= INIT_ERR;
      v_q        <= '0;
      r_q        <= '0;
    end else if (take) begin
      best_err_q <= diff[RATE_W-1:0];
      v_q        <= cand_v;
      r_q        <= cand_r;
    end
  end

  assign best_v = v_q;
  assign best_r = r_q;

endmodule

// File: rtl/pixclk_ratio_pack.sv
// Clamps the pair to 1..SEL_MAX and packs it minus one.
module pixclk_ratio_pack #(
  parameter int SEL_W   = 6,
  parameter int SEL_MAX = 63,
  parameter int CODE_W  = 16,
  parameter int V_LSB   = 8
) (
  input  logic [SEL_W-1:0]  sel_v,
  input  logic [SEL_W-1:0]  sel_r,
  output logic [CODE_W-1:0] code
);

  logic [SEL_W-1:0] v_cl, r_cl;

  always_comb begin
    v_cl = (sel_v == '0) ? SEL_W'(1) :
           ((sel_v > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel_v);
    r_cl = (sel_r == '0) ? SEL_W'(1) :
           ((sel_r > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel_r);
    code = '0;
    code[V_LSB +: SEL_W] = v_cl - SEL_W'(1);
    code[0 +: SEL_W]     = r_cl - SEL_W'(1);
  end

endmodule

// File: rtl/pixclk_ratio_search.sv
module pixclk_ratio_search
  import pixclk_ratio_pkg::*;
#(
  parameter int FREF_W  = 32,
  parameter int RATE_W  = 32,
  parameter int SEL_W   = 6,
  parameter int SEL_MAX = 63,
  parameter int SCALE   = 1000,
  parameter int STEPS   = 19,
  parameter int CODE_W  = 16,
  parameter int V_LSB   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREF_W-1:0] req_fref,
  input  logic [RATE_W-1:0] req_rate,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code
);

  localparam int PROD_W  = FREF_W + SEL_W;
  localparam int SCALE_W = $clog2(SCALE + 1);
  localparam int DIVR_W  = (SCALE_W > SEL_W) ? SCALE_W : SEL_W;

  search_state_e     state_q;
  logic [FREF_W-1:0] fref_q;
  logic [RATE_W-1:0] rate_q;
  logic [SEL_W-1:0]  v_q, r_q;
  logic [PROD_W-1:0] scaled_q;
  logic [CODE_W-1:0] code_q;

  logic              div_go, div_done;
  logic [PROD_W-1:0] div_dividend, div_quot;
  logic [DIVR_W-1:0] div_divisor;
  logic              accept, cand_valid;
  logic [SEL_W-1:0]  best_v, best_r;
  logic [CODE_W-1:0] packed_code;

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign cand_valid = (state_q == ST_WAIT_RATIO) && div_done;
  assign div_go     = (state_q == ST_KICK_SCALE) || (state_q == ST_KICK_RATIO);

  always_comb begin
    if (state_q == ST_KICK_SCALE) begin
      div_dividend = PROD_W'(v_q) * PROD_W'(fref_q);
      div_divisor  = DIVR_W'(SCALE);
    end else begin
      div_dividend = scaled_q;
      div_divisor  = DIVR_W'(r_q);
    end
  end

  pixclk_ratio_div #(
    .DVD_W(PROD_W), .DVS_W(DIVR_W), .STEPS(STEPS)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(div_dividend), .divisor(div_divisor),
    .done(div_done), .quotient(div_quot)
  );

  pixclk_ratio_best #(
    .FREQ_W(PROD_W), .RATE_W(RATE_W), .SEL_W(SEL_W)
  ) u_best (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .cand_valid(cand_valid), .cand_freq(div_quot),
    .cand_v(v_q), .cand_r(r_q), .target(rate_q),
    .best_v(best_v), .best_r(best_r)
  );

  pixclk_ratio_pack #(
    .SEL_W(SEL_W), .SEL_MAX(SEL_MAX), .CODE_W(CODE_W), .V_LSB(V_LSB)
  ) u_pack (
    .sel_v(best_v), .sel_r(best_r), .code(packed_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fref_q   <= '0;
      rate_q   <= '0;
      v_q      <= '0;
      r_q      <= '0;
      scaled_q <= '0;
      code_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          fref_q  <= req_fref;
          rate_q  <= req_rate;
          v_q     <= SEL_W'(SEL_MAX);
          r_q     <= SEL_W'(SEL_MAX);
          state_q <= ST_KICK_SCALE;
        end
        ST_KICK_SCALE: state_q <= ST_WAIT_SCALE;
        ST_WAIT_SCALE: if (div_done) begin
          scaled_q <= div_quot;
          state_q  <= ST_KICK_RATIO;
        end
        ST_KICK_RATIO: state_q <= ST_WAIT_RATIO;
        ST_WAIT_RATIO: if (div_done) begin
          if (r_q != SEL_W'(1)) begin
            r_q     <= r_q - SEL_W'(1);
            state_q <= ST_KICK_RATIO;
          end else if (v_q != SEL_W'(1)) begin
            v_q     <= v_q - SEL_W'(1);
            r_q     <= SEL_W'(SEL_MAX);
            state_q <= ST_KICK_SCALE;
          end else begin
            state_q <= ST_PACK;
          end
        end
        ST_PACK: begin
          code_q  <= packed_code;
          state_q <= ST_REPORT;
        end
        ST_REPORT: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_REPORT);
  assign res_code  = code_q;

endmodule

// File: rtl/pixclk_ratio_search_chk.sv
module pixclk_ratio_search_chk #(
  parameter int SEL_W  = 6,
  parameter int CODE_W = 16,
  parameter int V_LSB  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic [CODE_W-1:0] res_code
);

  localparam logic [CODE_W-1:0] FIELD_MASK =
    (CODE_W'({SEL_W{1'b1}}) << V_LSB) | CODE_W'({SEL_W{1'b1}});

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_PULSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R2
  AST_READY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> req_ready); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_CODE_MOVES_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_code) |-> res_valid); // R7
  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_code & ~FIELD_MASK) == '0)); // R6

endmodule

bind pixclk_ratio_search pixclk_ratio_search_chk #(
  .SEL_W(SEL_W), .CODE_W(CODE_W), .V_LSB(V_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_code(res_code)
);

// File: tb/pixclk_ratio_search_bench.sv
`timescale 1ns/1ps
module pixclk_ratio_search_bench;

  typedef struct packed {
    logic [31:0] fref;
    logic [31:0] rate;
    logic [15:0] code;
  } vec_t;

  // Rows: R4 tie to smallest zero-error pair; R3 exact top pair; R3 mid pair;
  // R3 full-width product; R5 and R6 nothing chosen, clamped to (1,1).
  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{32'd1000,       32'd0,          16'h0001},
    '{32'd1000,       32'd63,         16'h3E00},
    '{32'd2000,       32'd3,          16'h0201},
    '{32'hFFFF_FFFF,  32'd270582939,  16'h3E00},
    '{32'd1000,       32'hFFFF_FFFF,  16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_fref = '0;
  logic [31:0] req_rate = '0;
  logic        res_valid;
  logic [15:0] res_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pixclk_ratio_search u_pixclk_ratio_search (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fref(req_fref), .req_rate(req_rate),
    .res_valid(res_valid), .res_code(res_code)
  );

  function automatic string row_tag(input int i);
    case (i)
      0: return "R4";
      4: return "R5";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [15:0] ref_code(input logic [31:0] fref, input logic [31:0] rate);
    longint unsigned best = 64'd2147483647;
    longint unsigned f, e;
    int bv = 0;
    int br = 0;
    for (int v = 63; v >= 1; v--) begin
      for (int r = 63; r >= 1; r--) begin
        f = ((longint'(v) * longint'(fref)) / 1000) / longint'(r);
        e = (f > longint'(rate)) ? f - longint'(rate) : longint'(rate) - f;
        if (e <= best) begin
          best = e; bv = v; br = r;
        end
      end
    end
    if (bv < 1) bv = 1;
    if (br < 1) br = 1;
    return 16'(((bv - 1) << 8) | (br - 1));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_result(output logic [15:0] code);
    int n = 0;
    while (!res_valid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(res_valid == 1'b1, "R7 result pulse seen", 32'(res_valid), 32'd1);
    code = res_code;
  endtask

  task automatic after_pulse(input logic [15:0] code);
    @(negedge clk);
    check(res_valid == 1'b0, "R7 pulse lasts one cycle", 32'(res_valid), 32'd0);
    check(req_ready == 1'b1, "R2 ready back after pulse", 32'(req_ready), 32'd1);
    check(res_code == code, "R7 code held after pulse", 32'(res_code), 32'(code));
  endtask

  task automatic run_search(input logic [31:0] f, input logic [31:0] t, output logic [15:0] code);
    @(negedge clk);
    req_fref = f; req_rate = t; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 32'd0);
    wait_result(code);
    after_pulse(code);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    repeat (90000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
    check(res_valid == 1'b0, "R1 no pulse in reset", 32'(res_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    check(res_valid == 1'b0, "R1 no pulse after reset", 32'(res_valid), 32'd0);
    check(res_code == 16'h0000, "R1 code after reset", 32'(res_code), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      run_search(VECS[i].fref, VECS[i].rate, got);
      check(got == VECS[i].code, {row_tag(i), " table vector"}, 32'(got), 32'(VECS[i].code));
      if (i == 4)
        check(got == 16'h0000, "R6 clamp to pair (1,1)", 32'(got), 32'd0);
    end

    // R3: realistic rates against the bench reference loop
    exp = ref_code(32'd24000000, 32'd25175000);
    run_search(32'd24000000, 32'd25175000, got);
    check(got == exp, "R3 reference loop", 32'(got), 32'(exp));

    // R7: code held while idle
    repeat (20) @(negedge clk);
    check(res_code == got, "R7 code held while idle", 32'(res_code), 32'(got));

    // R2: inputs changed mid-search and request held across the pulse
    @(negedge clk);
    req_fref = 32'd2000; req_rate = 32'd3; req_valid = 1'b1;
    @(negedge clk);
    req_fref = 32'd1000; req_rate = 32'd63;
    check(req_ready == 1'b0, "R2 busy while request held", 32'(req_ready), 32'd0);
    wait_result(got);
    check(got == 16'h0201, "R2 mid-search inputs ignored", 32'(got), 32'h0201);
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready on cycle after pulse", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 held request accepted", 32'(req_ready), 32'd0);
    wait_result(got);
    check(got == 16'h3E00, "R2 held request result", 32'(got), 32'h3E00);
    after_pulse(got);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule